// File: doc/BRIEF.md
# Disk Head Step Positioner

This block moves a floppy-disk read/write head from the track it is on to a commanded track. It keeps its own record of the head's track, issues one step pulse per track with a direction level, and holds each pulse wide enough and each step far enough from the last to respect the mechanism's slow step rate. The direction level is set up a configurable number of cycles before each pulse and held steady through it.

A separate initialize request recalibrates the head. The block steps outward until the drive's track-zero sense is seen and then clears its track record. If the sense never appears within a bounded number of steps, an error is flagged. Requests for a track beyond the last one are refused at once with a range error. The block also outputs a reduced write-current select for the inner tracks, and a head-load level that follows the read/write request.

Top module: `head_positioner`

## Requirements
- R1: `dir_out` low means a step toward the spindle, and the track register rises by 1 in the cycle `step_out` rises. `dir_out` high means a step toward the rim, and the register falls by 1 there, stopping at 0. A seek drives `dir_out` low when the target is above the current track and high when it is below. It issues exactly |target - current| steps and ends with `cur_track` equal to the target.
- R2: Successive rising edges of `step_out` are at least STEP_PERIOD clock cycles apart.
- R3: Each `step_out` pulse stays high for at least PULSE_CYC cycles.
- R4: `low_current` is 1 exactly while `cur_track` is greater than 43.
- R5: `dir_out` holds its value for at least DIR_SETUP cycles before each rising edge of `step_out`, and stays unchanged while `step_out` is high.
- R6: `init_req` accepted while idle starts a recalibration. The block issues outward steps (`dir_out` = 1) until `track0_in` is 1 at a decision point, then sets `cur_track` to 0, clears `seek_err` and pulses `done`. If `track0_in` is already 1, it issues no step.
- R7: If `track0_in` has not been seen after RECAL_LIMIT (80) outward steps, recalibration stops, sets `seek_err` to 1 and pulses `done`.
- R8: A seek to a target above MAX_TRACK (76) issues no step and leaves `cur_track` unchanged. It sets `range_err` to 1 and pulses `done` in the next cycle without raising `busy`. The next accepted request clears `range_err`.
- R9: `head_load` equals `rw_req` delayed by one clock.
- R10: After reset, `cur_track` is 0 and `busy`, `done`, `step_out`, `head_load`, `low_current`, `seek_err` and `range_err` are 0. `busy` is 1 from the cycle after an accepted in-range request until the operation ends. `done` is a single-cycle pulse that comes in the cycle `busy` falls. `init_req` takes priority over `seek_req` when both arrive in the same idle cycle.
- R11: `seek_req` and `init_req` that arrive while `busy` is 1 are ignored.
- R12: A seek to the track the head is already on issues no step and pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start recalibration to track 0 (sampled when idle) |
| seek_req | input | 1 | Start a seek to `target` (sampled when idle) |
| target | input | TRACK_W | Commanded track |
| rw_req | input | 1 | Read/write operation in progress |
| track0_in | input | 1 | Drive senses the head over track 0 |
| step_out | output | 1 | Step pulse to the head mechanism |
| dir_out | output | 1 | Step direction: 0 toward the spindle, 1 toward the rim |
| head_load | output | 1 | Load head against the media |
| low_current | output | 1 | Select the reduced write current |
| cur_track | output | TRACK_W | Track the head is on |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| seek_err | output | 1 | Recalibration gave up without seeing track 0 |
| range_err | output | 1 | Last seek target was beyond the last track |

## Verification
The bench runs seeks in a chain across the track range, mostly to targets from a modular sweep, plus the edges 0, 43, 44 and 76. Moves therefore run both inward and outward, with lengths from one track to the full span, and the step counts and final tracks separate a wrong direction from a wrong count. Its drive model moves a simulated head on each pulse and raises track zero from that position. This lets recalibration from a non-zero start be told apart from one that merely clears the register, and a stuck sensor exposes the step limit. Out-of-range targets, a seek to the current track and requests sent while busy separate refusal, a zero-length move and a dropped request from a real move.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SETUP,
        ST_PULSE,
        ST_GAP
    } hp_state_e;

    typedef enum logic {
        MV_SEEK,
        MV_RECAL
    } hp_mode_e;

    localparam logic DIR_INWARD  = 1'b0;
    localparam logic DIR_OUTWARD = 1'b1;

    typedef struct packed {
        logic step;
        logic outward;
        logic zero;
    } hp_trk_cmd_t;

    function automatic logic hp_dir_for(input int unsigned tgt, input int unsigned cur);
        return (tgt < cur) ? DIR_OUTWARD : DIR_INWARD;
    endfunction

endpackage

// File: rtl/hp_track.sv
module hp_track
    import hp_pkg::*;
#(
    parameter int TRACK_W      = 7,
    parameter int LOWCUR_ABOVE = 43
) (
    input  logic               clk,
    input  logic               rst,
    input  hp_trk_cmd_t        cmd,
    output logic [TRACK_W-1:0] cur_track,
    output logic               low_current
);
    localparam logic [TRACK_W-1:0] LOWCUR_LIM = TRACK_W'(LOWCUR_ABOVE);

    logic [TRACK_W-1:0] trk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else if (cmd.zero) begin
            trk_q <= '0;
        end else if (cmd.step) begin
            if (cmd.outward) begin
                if (trk_q != '0) trk_q <= trk_q - 1'b1;
            end else begin
                trk_q <= trk_q + 1'b1;
            end
        end
    end

    assign cur_track   = trk_q;
    assign low_current = (trk_q > LOWCUR_LIM);
endmodule

// File: rtl/hp_load.sv
module hp_load (
    input  logic clk,
    input  logic rst,
    input  logic rw_req,
    output logic head_load
);
    always_ff @(posedge clk) begin
        if (rst) head_load <= 1'b0;
        else     head_load <= rw_req;
    end
endmodule

// File: rtl/hp_seq.sv
module hp_seq
    import hp_pkg::*;
#(
    parameter int TRACK_W     = 7,
    parameter int MAX_TRACK   = 76,
    parameter int STEP_PERIOD = 500000,
    parameter int PULSE_CYC   = 10,
    parameter int DIR_SETUP   = 2,
    parameter int RECAL_LIMIT = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_req,
    input  logic               seek_req,
    input  logic [TRACK_W-1:0] target,
    input  logic               track0_in,
    input  logic [TRACK_W-1:0] cur_track,
    output hp_trk_cmd_t        cmd,
    output logic               step_out,
    output logic               dir_out,
    output logic               busy,
    output logic               done,
    output logic               seek_err,
    output logic               range_err
);
    localparam int CNT_W = $clog2(STEP_PERIOD + DIR_SETUP + PULSE_CYC + 1);
    localparam int NST_W = $clog2(RECAL_LIMIT + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(DIR_SETUP - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(STEP_PERIOD - 1);
    localparam logic [NST_W-1:0] NST_LIM    = NST_W'(RECAL_LIMIT);
    localparam logic [TRACK_W-1:0] MAX_T    = TRACK_W'(MAX_TRACK);

    hp_state_e          state;
    hp_mode_e           mode;
    logic [CNT_W-1:0]   cnt;
    logic [NST_W-1:0]   nsteps;
    logic [TRACK_W-1:0] tgt_q;
    logic               dir_q;
    logic               launch;

    assign launch      = (state == ST_SETUP) && (cnt == SETUP_LAST);
    assign cmd.step    = launch;
    assign cmd.outward = dir_q;
    assign cmd.zero    = (state == ST_DECIDE) && (mode == MV_RECAL) && track0_in;

    assign step_out = (state == ST_PULSE);
    assign dir_out  = dir_q;
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode      <= MV_SEEK;
            cnt       <= '0;
            nsteps    <= '0;
            tgt_q     <= '0;
            dir_q     <= DIR_INWARD;
            done      <= 1'b0;
            seek_err  <= 1'b0;
            range_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (init_req) begin
                        mode      <= MV_RECAL;
                        nsteps    <= '0;
                        seek_err  <= 1'b0;
                        range_err <= 1'b0;
                        state     <= ST_DECIDE;
                    end else if (seek_req) begin
                        seek_err <= 1'b0;
                        if (target > MAX_T) begin
                            range_err <= 1'b1;
                            done      <= 1'b1;
                        end else begin
                            range_err <= 1'b0;
                            tgt_q     <= target;
                            mode      <= MV_SEEK;
                            nsteps    <= '0;
                            state     <= ST_DECIDE;
                        end
                    end
                end
                ST_DECIDE: begin
                    cnt <= '0;
                    if (mode == MV_RECAL) begin
                        if (track0_in) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (nsteps == NST_LIM) begin
                            seek_err <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            dir_q <= DIR_OUTWARD;
                            state <= ST_SETUP;
                        end
                    end else begin
                        if (tgt_q == cur_track) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            dir_q <= hp_dir_for(int'(tgt_q), int'(cur_track));
                            state <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    if (launch) begin
                        cnt   <= '0;
                        state <= ST_PULSE;
                        if (nsteps != NST_LIM) nsteps <= nsteps + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PULSE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == PULSE_LAST) state <= ST_GAP;
                end
                ST_GAP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt >= GAP_LAST) state <= ST_DECIDE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/head_positioner.sv
module head_positioner
    import hp_pkg::*;
#(
    parameter int TRACK_W      = 7,
    parameter int MAX_TRACK    = 76,
    parameter int LOWCUR_ABOVE = 43,
    parameter int STEP_PERIOD  = 500000,
    parameter int PULSE_CYC    = 10,
    parameter int DIR_SETUP    = 2,
    parameter int RECAL_LIMIT  = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_req,
    input  logic               seek_req,
    input  logic [TRACK_W-1:0] target,
    input  logic               rw_req,
    input  logic               track0_in,
    output logic               step_out,
    output logic               dir_out,
    output logic               head_load,
    output logic               low_current,
    output logic [TRACK_W-1:0] cur_track,
    output logic               busy,
    output logic               done,
    output logic               seek_err,
    output logic               range_err
);
    hp_trk_cmd_t trk_cmd;

    hp_seq #(
        .TRACK_W    (TRACK_W),
        .MAX_TRACK  (MAX_TRACK),
        .STEP_PERIOD(STEP_PERIOD),
        .PULSE_CYC  (PULSE_CYC),
        .DIR_SETUP  (DIR_SETUP),
        .RECAL_LIMIT(RECAL_LIMIT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .init_req (init_req),
        .seek_req (seek_req),
        .target   (target),
        .track0_in(track0_in),
        .cur_track(cur_track),
        .cmd      (trk_cmd),
        .step_out (step_out),
        .dir_out  (dir_out),
        .busy     (busy),
        .done     (done),
        .seek_err (seek_err),
        .range_err(range_err)
    );

    hp_track #(
        .TRACK_W     (TRACK_W),
        .LOWCUR_ABOVE(LOWCUR_ABOVE)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .cmd        (trk_cmd),
        .cur_track  (cur_track),
        .low_current(low_current)
    );

    hp_load u_load (
        .clk      (clk),
        .rst      (rst),
        .rw_req   (rw_req),
        .head_load(head_load)
    );
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
    parameter int TRACK_W     = 7,
    parameter int STEP_PERIOD = 500000,
    parameter int PULSE_CYC   = 10,
    parameter int DIR_SETUP   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               step_out,
    input logic               dir_out,
    input logic [TRACK_W-1:0] cur_track,
    input logic               busy,
    input logic               done,
    input logic               range_err
);
    localparam int SP_W = $clog2(STEP_PERIOD + 1) + 1;
    localparam int PW_W = $clog2(PULSE_CYC + 1) + 1;
    localparam int DS_W = $clog2(DIR_SETUP + 1) + 1;
    localparam logic [SP_W-1:0] SP_SAT = SP_W'(STEP_PERIOD);
    localparam logic [PW_W-1:0] PW_SAT = PW_W'(PULSE_CYC);
    localparam logic [DS_W-1:0] DS_SAT = DS_W'(DIR_SETUP);

    logic            step_q;
    logic            dir_q;
    logic [SP_W-1:0] since_rise;
    logic [PW_W-1:0] high_len;
    logic [DS_W-1:0] dir_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q     <= 1'b0;
            dir_q      <= dir_out;
            since_rise <= SP_SAT;
            high_len   <= '0;
            dir_age    <= DS_SAT;
        end else begin
            step_q <= step_out;
            dir_q  <= dir_out;
            if (step_out && !step_q)   since_rise <= SP_W'(1);
            else if (since_rise < SP_SAT) since_rise <= since_rise + 1'b1;
            if (step_out) begin
                if (high_len < PW_SAT) high_len <= high_len + 1'b1;
            end else begin
                high_len <= '0;
            end
            if (dir_out != dir_q)       dir_age <= '0;
            else if (dir_age < DS_SAT)  dir_age <= dir_age + 1'b1;
        end
    end

    AST_STEP_INWARD_INC: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out) && !dir_out) |-> (cur_track == $past(cur_track) + 1'b1)) // R1
        else $error("inward step did not increment track");

    AST_STEP_OUTWARD_DEC: assert property (@(posedge clk) disable iff (rst)
        ($rose(step_out) && dir_out && ($past(cur_track) != '0))
            |-> (cur_track == $past(cur_track) - 1'b1)) // R1
        else $error("outward step did not decrement track");

    AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
        (step_out && !step_q) |-> (since_rise >= SP_SAT)) // R2
        else $error("steps too close");

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!step_out && step_q) |-> (high_len >= PW_SAT)) // R3
        else $error("step pulse too narrow");

    AST_DIR_SETUP: assert property (@(posedge clk) disable iff (rst)
        (step_out && !step_q) |-> (dir_age + 1'b1 >= DS_SAT)) // R5
        else $error("direction setup too short");

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        step_out |-> $stable(dir_out)) // R5
        else $error("direction changed during pulse");

    AST_RANGE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        $rose(range_err) |-> (!busy && !step_out && done)) // R8
        else $error("range reject moved or stayed silent");

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done) // R10
        else $error("busy fell without done");

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R10
        else $error("done longer than one cycle");
endmodule

bind head_positioner hp_checker #(
    .TRACK_W    (TRACK_W),
    .STEP_PERIOD(STEP_PERIOD),
    .PULSE_CYC  (PULSE_CYC),
    .DIR_SETUP  (DIR_SETUP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_out (step_out),
    .dir_out  (dir_out),
    .cur_track(cur_track),
    .busy     (busy),
    .done     (done),
    .range_err(range_err)
);

// File: tb/head_positioner_tb.sv
`timescale 1ns/1ps
module head_positioner_tb;
    localparam int TW   = 7;
    localparam int SP   = 12;
    localparam int PW   = 4;
    localparam int DS   = 3;
    localparam int MAXT = 76;
    localparam int LIM  = 80;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, init_req = 1'b0, seek_req = 1'b0, rw_req = 1'b0;
    logic [TW-1:0] target = '0;
    logic track0_in;
    logic step_out, dir_out, head_load, low_current, busy, done, seek_err, range_err;
    logic [TW-1:0] cur_track;

    head_positioner #(
        .TRACK_W(TW), .MAX_TRACK(MAXT), .LOWCUR_ABOVE(43),
        .STEP_PERIOD(SP), .PULSE_CYC(PW), .DIR_SETUP(DS), .RECAL_LIMIT(LIM)
    ) u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .seek_req(seek_req),
        .target(target), .rw_req(rw_req), .track0_in(track0_in),
        .step_out(step_out), .dir_out(dir_out), .head_load(head_load),
        .low_current(low_current), .cur_track(cur_track), .busy(busy),
        .done(done), .seek_err(seek_err), .range_err(range_err)
    );

    int n_chk = 0, n_bad = 0;
    int pos = 5;
    bit stuck = 0;
    int inc_n = 0, dec_n = 0;
    int sp = 1000000, hi = 0, dage = 1000000;
    int min_sp = 1000000, min_pw = 1000000, min_ds = 1000000;
    logic step_q = 1'b0, dir_q = 1'b0;
    bit finished = 0;

    assign track0_in = !stuck && (pos == 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive model and pulse timing monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (sp < 1000000) sp++;
            if (dir_out != dir_q) dage = 0;
            else if (dage < 1000000) dage++;
            dir_q = dir_out;
            if (step_out) hi++;
            if (step_out && !step_q) begin
                if (dir_out) begin
                    dec_n++;
                    if (pos > 0) pos--;
                end else begin
                    inc_n++;
                    pos++;
                end
                if (sp < min_sp) min_sp = sp;
                if (dage < min_ds) min_ds = dage;
                sp = 0;
            end
            if (!step_out && step_q) begin
                if (hi < min_pw) min_pw = hi;
                hi = 0;
            end
            step_q = step_out;
        end
    end

    task automatic request(input bit is_init, input int t);
        @(negedge clk);
        target   = TW'(t);
        init_req = is_init;
        seek_req = !is_init;
        @(negedge clk);
        init_req = 1'b0;
        seek_req = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!done && k < 6000) begin
            @(negedge clk);
            k++;
        end
        chk(done === 1'b1, req, k, -1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 done single cycle", int'(done), 0);
    endtask

    task automatic do_seek(input int t, input string req);
        int from = int'(cur_track);
        int inc_e = (t > from) ? t - from : 0;
        int dec_e = (t < from) ? from - t : 0;
        inc_n = 0; dec_n = 0;
        request(0, t);
        wait_done(req);
        chk(int'(cur_track) == t, {req, " R1 final track"}, int'(cur_track), t);
        chk(pos == t, {req, " R1 head position"}, pos, t);
        chk(inc_n == inc_e, {req, " R1 inward steps"}, inc_n, inc_e);
        chk(dec_n == dec_e, {req, " R1 outward steps"}, dec_n, dec_e);
        chk(low_current == (t > 43), "R4 low current", int'(low_current), int'(t > 43));
        chk(range_err == 1'b0, "R8 range_err clear", int'(range_err), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cur_track == '0, "R10 reset track", int'(cur_track), 0);
        chk({busy, done, step_out, head_load, low_current, seek_err, range_err} == '0,
            "R10 reset outputs", int'({busy, done, step_out, head_load, low_current, seek_err, range_err}), 0);

        // R6 recalibrate from head at track 5, register at 0
        inc_n = 0; dec_n = 0;
        request(1, 0);
        chk(busy === 1'b1, "R10 busy after init", int'(busy), 1);
        wait_done("R6 recal done");
        chk(dec_n == 5 && inc_n == 0, "R6 outward steps", dec_n, 5);
        chk(cur_track == '0 && pos == 0, "R6 track zero", int'(cur_track), 0);
        chk(seek_err == 1'b0, "R6 no seek_err", int'(seek_err), 0);

        // R9 head load follows rw_req
        @(negedge clk); rw_req = 1'b1;
        @(negedge clk); chk(head_load === 1'b1, "R9 head load on", int'(head_load), 1);
        rw_req = 1'b0;
        @(negedge clk); chk(head_load === 1'b0, "R9 head load off", int'(head_load), 0);

        // R12 seek to current track
        inc_n = 0; dec_n = 0;
        request(0, 0);
        wait_done("R12 zero-length done");
        chk(inc_n + dec_n == 0, "R12 no steps", inc_n + dec_n, 0);

        // R1 R4 sweep of seeks
        for (int i = 0; i < 14; i++) begin
            int t;
            if (i < 10) t = (i * 37 + 11) % 77;
            else case (i)
                10: t = 76;
                11: t = 44;
                12: t = 43;
                default: t = 0;
            endcase
            do_seek(t, "R1 sweep seek");
        end

        // R8 out of range
        do_seek(20, "R8 setup seek");
        for (int j = 0; j < 2; j++) begin
            int bad = (j == 0) ? 77 : 127;
            inc_n = 0; dec_n = 0;
            request(0, bad);
            chk(busy === 1'b0 && done === 1'b1, "R8 immediate done", int'(done), 1);
            wait_done("R8 reject done");
            chk(range_err === 1'b1, "R8 range_err set", int'(range_err), 1);
            chk(inc_n + dec_n == 0, "R8 no step", inc_n + dec_n, 0);
            chk(int'(cur_track) == 20, "R8 track kept", int'(cur_track), 20);
        end
        do_seek(21, "R8 clear by next seek");

        // R11 requests while busy are ignored
        inc_n = 0; dec_n = 0;
        request(0, 30);
        repeat (20) @(negedge clk);
        request(0, 60);
        request(1, 0);
        wait_done("R11 busy seek done");
        chk(int'(cur_track) == 30, "R11 track", int'(cur_track), 30);
        chk(inc_n == 9 && dec_n == 0, "R11 step count", inc_n, 9);

        // R7 stuck sensor hits step limit
        stuck = 1;
        inc_n = 0; dec_n = 0;
        request(1, 0);
        wait_done("R7 limit done");
        chk(seek_err === 1'b1, "R7 seek_err", int'(seek_err), 1);
        chk(dec_n == LIM, "R7 step count", dec_n, LIM);
        stuck = 0;
        inc_n = 0; dec_n = 0;
        request(1, 0);
        wait_done("R6 immediate recal done");
        chk(seek_err === 1'b0 && inc_n + dec_n == 0, "R6 no step at track zero", inc_n + dec_n, 0);

        // timing over the whole run
        chk(min_sp >= SP, "R2 step spacing", min_sp, SP);
        chk(min_pw >= PW, "R3 pulse width", min_pw, PW);
        chk(min_ds >= DS, "R5 direction setup", min_ds, DS);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule